// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

The engine walks a ring of transmit buffer descriptors in system memory each time software kicks it. Each descriptor takes two 32-bit words. The first word holds a 16-bit flag field in its upper half and a 16-bit byte count in its lower half. The second word holds the byte address of the data buffer. The engine reads each ready descriptor and fetches its buffer one word at a time. It appends the bytes to a frame store held inside the block. Once a descriptor is done, the engine writes the descriptor's first word back with the ownership bit cleared.

A frame may span several descriptors. When a descriptor carries the end-of-frame flag, the engine sends the gathered frame out as a byte stream, one byte per cycle, marked at its first and last byte. Event pulses report each finished descriptor, each finished frame and each oversize frame. The descriptor pointer is kept between kicks, so software can go on filling the ring and kick again.

A write to the ring-start input while the engine is busy changes only the address that a wrapping descriptor returns to. The pointer of the walk in progress is left alone.

Top module: `txdesc_gather`

## Requirements
- R1: A kick starts a walk only when `ctrl_en` is high and no walk is running. A kick with `ctrl_en` low makes no memory access and raises no event. After reset, every output stays low until a walk starts.
- R2: The first word of a descriptor holds the flags in bits 31:16 and the byte count in bits 15:0. The second word, at descriptor address + 4, holds the buffer address. The walk ends at the first descriptor whose flag bit 15 (word bit 31) is clear, and that descriptor is not written back.
- R3: Each consumed descriptor has its first word written back with bit 31 cleared. All other flag bits and the byte count keep their values. One `ev_buf_done` pulse is raised per consumed descriptor.
- R4: The next descriptor sits at the current address + 8. When flag bit 13 (word bit 29) is set, the next descriptor is at the ring start instead.
- R5: Buffer bytes are sent in address order. Within each fetched word, the most significant byte comes first. The first byte is taken from the byte lane given by buffer address bits 1:0. Buffers of successive descriptors are joined into one frame.
- R6: On a descriptor with flag bit 11 (word bit 27) set, the gathered frame is sent with `tx_sof` on its first byte and `tx_eof` on its last. One `ev_frame_done` pulse is raised, and the frame length goes back to zero. A frame of zero bytes sends nothing but still raises the pulse.
- R7: If a descriptor would take the frame past MAX_FRAME (2032) bytes, only the bytes that still fit are copied, and one `ev_babble` pulse is raised.
- R8: A single kick consumes at most MAX_DESC (1024) descriptors. The pointer stays where the walk stopped, and the next kick resumes from there.
- R9: A ring-start write while idle reloads the descriptor pointer, with address bits 1:0 forced to zero. If the write comes in the same cycle as an accepted kick, the walk begins at the newly written address.
- R10: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller enable; a kick is ignored while low |
| kick | input | 1 | Start-walk pulse |
| ring_base | input | 32 | Ring start address |
| ring_base_wr | input | 1 | Write strobe for `ring_base` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the request |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| ev_buf_done | output | 1 | Pulse per consumed descriptor |
| ev_frame_done | output | 1 | Pulse per completed frame |
| ev_babble | output | 1 | Pulse when a frame is clipped |
| walk_busy | output | 1 | A walk is in progress |

## Verification
A ring-start write and a kick can land in the same cycle. That cycle decides whether the walk starts from the old pointer or from the new address. The bench first points the ring start at an empty area of memory, then drives a new unaligned ring-start write together with the kick. A reference walk run from the new address then has to match the emitted byte stream, the event counts and the written-back memory image exactly. If the old pointer won, the walk would find no ready descriptor and emit nothing, so the comparison would catch it.

// File: rtl/txdg_pkg.sv
package txdg_pkg;
  // Flag bit positions inside the 16-bit descriptor flag field
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int DESC_STEP  = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_PTR,
    S_FETCH,
    S_PUSH,
    S_EMIT_GO,
    S_EMIT_WAIT,
    S_WB
  } walk_state_t;
endpackage

// File: rtl/txdg_frame_ram.sv
module txdg_frame_ram #(
  parameter int DEPTH = 2032,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  // Simple dual-port byte store with a registered read, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/txdg_emitter.sv
module txdg_emitter #(
  parameter int MAX_FRAME = 2032,
  localparam int AW     = $clog2(MAX_FRAME),
  localparam int FLEN_W = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FLEN_W-1:0] len,
  output logic [AW-1:0]     rd_addr,
  output logic              tx_valid,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              busy
);
  logic              active_q;
  logic [FLEN_W-1:0] idx_q;
  logic [FLEN_W-1:0] last_q;
  logic              v_q, sof_q, eof_q;

  assign rd_addr = idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      v_q      <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
    end else begin
      // One cycle behind the read address: matches the RAM output register
      v_q   <= active_q;
      sof_q <= active_q && (idx_q == '0);
      eof_q <= active_q && (idx_q == last_q);
      if (active_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == last_q) active_q <= 1'b0;
      end else if (start && (len != '0)) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        last_q   <= len - 1'b1;
      end
    end
  end

  assign tx_valid = v_q;
  assign tx_sof   = sof_q;
  assign tx_eof   = eof_q;
  assign busy     = active_q | v_q;

  assert_marks_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid);
endmodule

// File: rtl/txdg_walker.sv
module txdg_walker
  import txdg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024,
  localparam int FLEN_W = $clog2(MAX_FRAME + 1),
  localparam int CNT_W  = $clog2(MAX_DESC + 1),
  localparam int RAM_AW = $clog2(MAX_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              kick,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              ring_base_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              emit_start,
  output logic [FLEN_W-1:0] emit_len,
  input  logic              emit_busy,
  output logic              ev_buf,
  output logic              ev_frame,
  output logic              ev_babble,
  output logic              busy
);
  walk_state_t       st_q;
  logic [ADDR_W-1:0] desc_ptr, base_q, cur_q;
  logic [15:0]       hdr_flags, hdr_len, remain_q;
  logic [31:0]       word_q;
  logic [FLEN_W-1:0] flen_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [15:0]       room, take;
  logic              clip, is_last, is_wrap;
  logic [ADDR_W-1:0] base_in, next_desc;
  logic [7:0]        pick;

  assign room      = 16'(MAX_FRAME) - 16'(flen_q);
  assign clip      = hdr_len > room;
  assign take      = clip ? room : hdr_len;
  assign is_last   = hdr_flags[FLAG_LAST];
  assign is_wrap   = hdr_flags[FLAG_WRAP];
  assign base_in   = ring_base & ~ADDR_W'(3);
  assign next_desc = is_wrap ? base_q : desc_ptr + ADDR_W'(DESC_STEP);

  always_comb begin
    unique case (cur_q[1:0])
      2'd0: pick = word_q[31:24];
      2'd1: pick = word_q[23:16];
      2'd2: pick = word_q[15:8];
      default: pick = word_q[7:0];
    endcase
  end

  // Memory port driven from state registers only
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = {1'b0, hdr_flags[14:0], hdr_len};
    unique case (st_q)
      S_HDR:   mem_req = 1'b1;
      S_PTR:   begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(4); end
      S_FETCH: begin mem_req = 1'b1; mem_addr = cur_q & ~ADDR_W'(3); end
      S_WB:    begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign ram_we     = (st_q == S_PUSH);
  assign ram_waddr  = flen_q[RAM_AW-1:0];
  assign ram_wdata  = pick;
  assign emit_start = (st_q == S_EMIT_GO);
  assign emit_len   = flen_q;
  assign busy       = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      desc_ptr  <= '0;
      base_q    <= '0;
      cur_q     <= '0;
      hdr_flags <= '0;
      hdr_len   <= '0;
      remain_q  <= '0;
      word_q    <= '0;
      flen_q    <= '0;
      cnt_q     <= '0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
    end else begin
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
      if (ring_base_wr) base_q <= base_in;
      unique case (st_q)
        S_IDLE: begin
          if (ring_base_wr) desc_ptr <= base_in;
          if (kick && ctrl_en) begin
            st_q  <= S_HDR;
            cnt_q <= '0;
          end
        end
        S_HDR: if (mem_ack) begin
          hdr_flags <= mem_rdata[31:16];
          hdr_len   <= mem_rdata[15:0];
          st_q      <= mem_rdata[16 + FLAG_READY] ? S_PTR : S_IDLE;
        end
        S_PTR: if (mem_ack) begin
          cur_q     <= mem_rdata;
          remain_q  <= take;
          ev_babble <= clip;
          if (take != '0) st_q <= S_FETCH;
          else            st_q <= is_last ? S_EMIT_GO : S_WB;
        end
        S_FETCH: if (mem_ack) begin
          word_q <= mem_rdata;
          st_q   <= S_PUSH;
        end
        S_PUSH: begin
          flen_q   <= flen_q + 1'b1;
          cur_q    <= cur_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (remain_q == 16'd1)      st_q <= is_last ? S_EMIT_GO : S_WB;
          else if (cur_q[1:0] == 2'd3) st_q <= S_FETCH;
        end
        S_EMIT_GO: st_q <= S_EMIT_WAIT;
        S_EMIT_WAIT: if (!emit_busy) st_q <= S_WB;
        S_WB: if (mem_ack) begin
          ev_buf   <= 1'b1;
          if (is_last) begin
            ev_frame <= 1'b1;
            flen_q   <= '0;
          end
          desc_ptr <= next_desc;
          cnt_q    <= cnt_q + 1'b1;
          st_q     <= (cnt_q + 1'b1 == CNT_W'(MAX_DESC)) ? S_IDLE : S_HDR;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_wb_owner_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!mem_wdata[31] && mem_addr == desc_ptr));

  assert_flen_cap_R7: assert property (@(posedge clk) disable iff (rst)
    flen_q <= FLEN_W'(MAX_FRAME));

  assert_desc_cap_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_DESC));
endmodule

// File: rtl/txdesc_gather.sv
module txdesc_gather #(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              kick,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              ring_base_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              ev_buf_done,
  output logic              ev_frame_done,
  output logic              ev_babble,
  output logic              walk_busy
);
  localparam int FLEN_W = $clog2(MAX_FRAME + 1);
  localparam int RAM_AW = $clog2(MAX_FRAME);

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]        ram_wdata;
  logic              emit_start, emit_busy;
  logic [FLEN_W-1:0] emit_len;

  txdg_walker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)) u_walker (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .kick(kick),
    .ring_base(ring_base), .ring_base_wr(ring_base_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .emit_start(emit_start), .emit_len(emit_len), .emit_busy(emit_busy),
    .ev_buf(ev_buf_done), .ev_frame(ev_frame_done), .ev_babble(ev_babble),
    .busy(walk_busy)
  );

  txdg_frame_ram #(.DEPTH(MAX_FRAME)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(tx_data)
  );

  txdg_emitter #(.MAX_FRAME(MAX_FRAME)) u_emit (
    .clk(clk), .rst(rst), .start(emit_start), .len(emit_len),
    .rd_addr(ram_raddr), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .busy(emit_busy)
  );

  assert_kick_gate_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_busy) |-> $past(kick && ctrl_en));

  assert_no_stream_idle_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> walk_busy);
endmodule

// File: tb/txdesc_gather_bench.sv
module txdesc_gather_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, ctrl_en, kick, ring_base_wr;
  logic [31:0] ring_base;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_sof, tx_eof;
  logic [7:0]  tx_data;
  logic        ev_buf_done, ev_frame_done, ev_babble, walk_busy;

  txdesc_gather u_txdesc_gather (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .kick(kick),
    .ring_base(ring_base), .ring_base_wr(ring_base_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done),
    .ev_babble(ev_babble), .walk_busy(walk_busy)
  );

  logic [31:0] mem  [0:8191];
  logic [31:0] rmem [0:8191];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Memory responder with 1..3 cycle latency
  int dly = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) dly <= 0;
    else if (mem_req && !mem_ack) begin
      if (dly == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[14:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[14:2]];
        dly <= int'($urandom % 3);
      end else dly <= dly - 1;
    end
  end

  // Output monitor, sampled on the falling edge
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  int ev_b, ev_f, ev_bb, rises;
  logic busy_d = 1'b0;
  always @(negedge clk) begin
    if (tx_valid) got_q.push_back({tx_sof, tx_eof, tx_data});
    if (ev_buf_done) ev_b++;
    if (ev_frame_done) ev_f++;
    if (ev_babble) ev_bb++;
    if (walk_busy && !busy_d) rises++;
    busy_d = walk_busy;
  end

  // Reference walk
  logic [31:0] m_ptr, m_base;
  logic [7:0]  fb[$];
  int e_txb, e_txf, e_bab, m_flen = 0;

  function automatic logic [7:0] rbyte(input logic [31:0] a);
    logic [31:0] w;
    w = rmem[a[14:2]];
    return w[8*(3 - int'(a[1:0])) +: 8];
  endfunction

  task automatic model_walk();
    int cnt = 0;
    while (cnt < 1024) begin
      logic [31:0] hdr, bp;
      int len;
      hdr = rmem[m_ptr[14:2]];
      if (!hdr[31]) break;
      len = int'(hdr[15:0]);
      bp = rmem[(m_ptr + 32'd4) >> 2];
      if (m_flen + len > 2032) begin len = 2032 - m_flen; e_bab++; end
      for (int i = 0; i < len; i++) fb.push_back(rbyte(bp + i));
      m_flen += len;
      if (hdr[27]) begin
        for (int j = 0; j < fb.size(); j++)
          exp_q.push_back({j == 0, j == fb.size() - 1, fb[j]});
        fb.delete();
        m_flen = 0;
        e_txf++;
      end
      e_txb++;
      rmem[m_ptr[14:2]] = hdr & ~32'h8000_0000;
      m_ptr = hdr[29] ? m_base : m_ptr + 32'd8;
      cnt++;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setw(input logic [31:0] a, input logic [31:0] v);
    mem[a[14:2]] = v;
    rmem[a[14:2]] = v;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8192; i++) begin mem[i] = '0; rmem[i] = '0; end
    for (int i = 32'h1000; i < 8192; i++) begin
      logic [31:0] r;
      r = $urandom;
      mem[i] = r; rmem[i] = r;
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                          input logic [15:0] len, input logic [31:0] bp);
    setw(a, {fl, len});
    setw(a + 4, bp);
  endtask

  task automatic base_write(input logic [31:0] a, input bit with_kick);
    @(negedge clk);
    ring_base = a; ring_base_wr = 1'b1; ctrl_en = 1'b1; kick = with_kick;
    @(negedge clk);
    ring_base_wr = 1'b0; kick = 1'b0;
  endtask

  task automatic do_kick(input bit en);
    @(negedge clk);
    ctrl_en = en; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_done();
    repeat (3) @(negedge clk);
    while (walk_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_obs();
    got_q.delete(); exp_q.delete();
    ev_b = 0; ev_f = 0; ev_bb = 0; rises = 0;
    e_txb = 0; e_txf = 0; e_bab = 0;
  endtask

  task automatic compare(input string tag);
    int bad_i = -1, diffs = 0;
    if (got_q.size() == exp_q.size()) begin
      for (int i = 0; i < got_q.size(); i++)
        if (got_q[i] !== exp_q[i] && bad_i < 0) bad_i = i;
      chk(bad_i < 0, {tag, " R5 R6 byte stream (first bad entry)"},
          bad_i < 0 ? 0 : longint'(got_q[bad_i]), bad_i < 0 ? 0 : longint'(exp_q[bad_i]));
    end else
      chk(1'b0, {tag, " R5 R6 stream length"}, got_q.size(), exp_q.size());
    chk(ev_b == e_txb, {tag, " R3 buffer events"}, ev_b, e_txb);
    chk(ev_f == e_txf, {tag, " R6 frame events"}, ev_f, e_txf);
    chk(ev_bb == e_bab, {tag, " R7 babble events"}, ev_bb, e_bab);
    for (int i = 0; i < 8192; i++) if (mem[i] !== rmem[i]) diffs++;
    chk(diffs == 0, {tag, " R2 R3 R4 memory image diffs"}, diffs, 0);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    rst = 1'b1; ctrl_en = 1'b0; kick = 1'b0; ring_base = '0; ring_base_wr = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    clear_all();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !tx_valid && !walk_busy && !ev_buf_done && !ev_frame_done && !ev_babble,
        "R1 reset idle outputs", {mem_req, tx_valid, walk_busy}, 0);

    // R1: disabled kick does nothing
    clear_obs();
    put_desc(32'h100, 16'h8800, 16'd4, 32'h4000);
    base_write(32'h100, 1'b0);
    do_kick(1'b0);
    repeat (30) @(negedge clk);
    chk(rises == 0, "R1 kick with enable low starts no walk", rises, 0);
    chk(ev_b == 0 && got_q.size() == 0, "R1 no events or bytes when disabled", ev_b, 0);
    compare("R1 untouched");

    // R9: decoy base, then write + kick in the same cycle, unaligned
    clear_obs();
    base_write(32'h300, 1'b0);
    m_base = 32'h100; m_ptr = 32'h100;
    model_walk();
    base_write(32'h102, 1'b1);
    wait_done();
    compare("R9 same-cycle base write and kick");

    // Random rings (R2..R6)
    for (int r = 0; r < 10; r++) begin
      logic [31:0] b;
      int n;
      clear_obs();
      b = 32'h200 + ($urandom % 32) * 8;
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        logic [15:0] fl;
        fl = 16'h8000 | 16'($urandom & 32'h0400);
        if (($urandom % 2) == 1 || i == n - 1) fl |= 16'h0800;
        if (i == n - 1) fl |= 16'h2000;
        put_desc(b + i * 8, fl, 16'($urandom % 41), 32'h4000 + i * 32'h100 + ($urandom % 4));
      end
      base_write(b, 1'b0);
      m_base = b; m_ptr = b;
      model_walk();
      do_kick(1'b1);
      wait_done();
      compare($sformatf("random ring %0d", r));
    end

    // R7: oversize frame clipped, exact-size frame not
    clear_all();
    clear_obs();
    put_desc(32'h800, 16'h8000, 16'd1000, 32'h4000);
    put_desc(32'h808, 16'h8000, 16'd1000, 32'h4400);
    put_desc(32'h810, 16'h8800, 16'd1000, 32'h4802);
    put_desc(32'h818, 16'h8000, 16'd1016, 32'h5000);
    put_desc(32'h820, 16'h8800, 16'd1016, 32'h5400);
    base_write(32'h800, 1'b0);
    m_base = 32'h800; m_ptr = 32'h800;
    model_walk();
    do_kick(1'b1);
    wait_done();
    chk(ev_bb == 1, "R7 exactly one clip for the 3000-byte frame", ev_bb, 1);
    compare("R7 oversize");

    // R8: per-kick descriptor cap and resume
    clear_all();
    clear_obs();
    for (int i = 0; i < 1100; i++) put_desc(i * 8, 16'h8800, 16'd1, 32'h6000 + (i % 4));
    base_write(32'h0, 1'b0);
    m_base = 32'h0; m_ptr = 32'h0;
    model_walk();
    do_kick(1'b1);
    wait_done();
    chk(ev_b == 1024, "R8 descriptors consumed by first kick", ev_b, 1024);
    compare("R8 first kick");
    clear_obs();
    model_walk();
    do_kick(1'b1);
    wait_done();
    chk(ev_b == 76, "R8 resume consumes the rest", ev_b, 76);
    compare("R8 second kick");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule